// File: doc/BRIEF.md
# UART Automatic Flow Controller

This block applies hardware flow control to one serial channel. On the receive side it compares the receive FIFO fill level with two programmable thresholds. When the FIFO is nearly full it throttles the remote sender, and it releases the sender once the FIFO has drained. It can throttle in two ways. The in-band method asks the transmitter to insert a programmable stop or resume character. The out-of-band method drives the RTS and/or DTR handshake lines low.

On the transmit side it gates new data characters. A received stop character (XOFF) pauses the local transmitter and a received resume character (XON) releases it. A low CTS or DSR line, when that line is enabled, also holds the transmitter. Matched control characters are filtered out of the receive stream. An inserted control character always takes precedence over queued data. The FIFO and the serializer are outside this block. The serializer reads `tx_allow` and the insert request only at a character boundary, so a character already on the wire always finishes.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset, `rts` and `dtr` are 1, `ins_req` is 0 and `tx_allow` is 1.
- R2: When the channel is not throttled and `rx_level` >= `cfg_hi_thresh` at a clock edge, the channel becomes throttled from that edge on. After that edge `rts` is 0 if `cfg_rtscts_en` is 1 and `dtr` is 0 if `cfg_dsrdtr_en` is 1.
- R3: When the channel is throttled and `rx_level` <= `cfg_lo_thresh` at a clock edge, the throttle is released from that edge on and `rts`/`dtr` return to 1.
- R4: A level strictly between the two thresholds leaves the throttle state unchanged.
- R5: With `cfg_inband_en` = 1, a throttle change raises `ins_req` after the same edge. `ins_code` is `cfg_xoff_char` when throttling and `cfg_xon_char` when releasing. `ins_req` stays high until a cycle in which `ins_ack` is 1 and drops after that edge.
- R6: A control character is never requested twice in a row. If the throttle returns to the last sent state before the request is acknowledged, the request is withdrawn, and no XON is requested unless an XOFF was sent.
- R7: With `cfg_inband_en` = 1, a valid received character equal to `cfg_xoff_char` makes `tx_allow` 0 after that edge. One equal to `cfg_xon_char` ends the pause. XOFF wins if both codes are equal.
- R8: `rx_store` is 0 in the cycle a matched XON/XOFF character is presented with `cfg_inband_en` = 1. It equals `rx_char_valid` for any other character, and for every character when in-band control is off, in which case no pause occurs.
- R9: With `cfg_rtscts_en` = 1, `cts` = 0 at an edge makes `tx_allow` 0 after it. The same holds for `cfg_dsrdtr_en` and `dsr`. A disabled line is ignored.
- R10: While `ins_req` is 1, `tx_allow` is 0.
- R11: With its enable at 0, `rts` (or `dtr`) stays 1 from the next edge on, even while throttled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_inband_en | input | 1 | Enable XON/XOFF control |
| cfg_rtscts_en | input | 1 | Enable RTS/CTS handshake |
| cfg_dsrdtr_en | input | 1 | Enable DSR/DTR handshake |
| cfg_xon_char | input | 8 | Resume character code |
| cfg_xoff_char | input | 8 | Stop character code |
| cfg_hi_thresh | input | LVL_W | Level that starts throttling |
| cfg_lo_thresh | input | LVL_W | Level that releases throttling |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_char_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| rx_store | output | 1 | Write the received character into the FIFO |
| cts | input | 1 | Remote ready to receive (1 = go) |
| dsr | input | 1 | Remote data set ready (1 = go) |
| rts | output | 1 | Local ready to receive (1 = go) |
| dtr | output | 1 | Local terminal ready (1 = go) |
| ins_req | output | 1 | Request to insert a control character |
| ins_code | output | 8 | Control character to insert |
| ins_ack | input | 1 | Serializer accepted the inserted character |
| tx_allow | output | 1 | Serializer may start the next data character |

## Verification
The two halves meet when a level crossing and a received XOFF arrive in the same cycle. The receive side then raises an XON insert while the transmit side enters pause. The bench drives the level below the low threshold together with a valid XOFF character. It then checks that the XON request appears, that data stays blocked, and that the insert is still offered while the channel is paused. It also acknowledges a pending XOFF in the very cycle the level keeps it throttled, and withdraws a request before acknowledgement, to show that no character repeats.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              throttled;
        logic              sent_stop;
        logic              req;
        logic [CHAR_W-1:0] code;
        logic              rts;
        logic              dtr;
    } rx_state_t;

    typedef struct packed {
        logic paused;
        logic hold;
    } tx_state_t;
endpackage

// File: rtl/fc_rx_throttle.sv
module fc_rx_throttle
    import flowctl_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inband_en,
    input  logic              rtscts_en,
    input  logic              dsrdtr_en,
    input  logic [CHAR_W-1:0] xon_char,
    input  logic [CHAR_W-1:0] xoff_char,
    input  logic [LVL_W-1:0]  hi_thresh,
    input  logic [LVL_W-1:0]  lo_thresh,
    input  logic [LVL_W-1:0]  level,
    input  logic              ack,
    output logic              req,
    output logic [CHAR_W-1:0] code,
    output logic              rts,
    output logic              dtr
);
    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // hysteresis between the two thresholds
        if (!st_q.throttled && level >= hi_thresh) begin
            st_d.throttled = 1'b1;
        end else if (st_q.throttled && level <= lo_thresh) begin
            st_d.throttled = 1'b0;
        end
        // the accepted character becomes the last one on the line
        if (ack && st_q.req) begin
            st_d.sent_stop = st_q.throttled;
        end
        // request only when the wanted character differs from the last sent
        st_d.req  = inband_en && (st_d.throttled != st_d.sent_stop);
        st_d.code = st_d.throttled ? xoff_char : xon_char;
        st_d.rts  = !(rtscts_en && st_d.throttled);
        st_d.dtr  = !(dsrdtr_en && st_d.throttled);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{throttled: 1'b0, sent_stop: 1'b0, req: 1'b0,
                      code: '0, rts: 1'b1, dtr: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign req  = st_q.req;
    assign code = st_q.code;
    assign rts  = st_q.rts;
    assign dtr  = st_q.dtr;
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate
    import flowctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inband_en,
    input  logic              rtscts_en,
    input  logic              dsrdtr_en,
    input  logic [CHAR_W-1:0] xon_char,
    input  logic [CHAR_W-1:0] xoff_char,
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              cts,
    input  logic              dsr,
    output logic              store,
    output logic              hold
);
    tx_state_t st_d, st_q;
    logic      hit_stop;
    logic      hit_go;
    logic      lines_ok;

    always_comb begin
        hit_stop = inband_en && char_valid && (char_in == xoff_char);
        hit_go   = inband_en && char_valid && (char_in == xon_char) && !hit_stop;
        lines_ok = (!rtscts_en || cts) && (!dsrdtr_en || dsr);
        st_d     = st_q;
        if (!inband_en) begin
            st_d.paused = 1'b0;
        end else if (hit_stop) begin
            st_d.paused = 1'b1;
        end else if (hit_go) begin
            st_d.paused = 1'b0;
        end
        st_d.hold = st_d.paused || !lines_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{paused: 1'b0, hold: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign store = char_valid && !hit_stop && !hit_go;
    assign hold  = st_q.hold;
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
    import flowctl_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_inband_en,
    input  logic              cfg_rtscts_en,
    input  logic              cfg_dsrdtr_en,
    input  logic [CHAR_W-1:0] cfg_xon_char,
    input  logic [CHAR_W-1:0] cfg_xoff_char,
    input  logic [LVL_W-1:0]  cfg_hi_thresh,
    input  logic [LVL_W-1:0]  cfg_lo_thresh,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              rx_char_valid,
    input  logic [CHAR_W-1:0] rx_char,
    output logic              rx_store,
    input  logic              cts,
    input  logic              dsr,
    output logic              rts,
    output logic              dtr,
    output logic              ins_req,
    output logic [CHAR_W-1:0] ins_code,
    input  logic              ins_ack,
    output logic              tx_allow
);
    logic tx_hold;

    fc_rx_throttle #(.LVL_W(LVL_W)) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .inband_en (cfg_inband_en),
        .rtscts_en (cfg_rtscts_en),
        .dsrdtr_en (cfg_dsrdtr_en),
        .xon_char  (cfg_xon_char),
        .xoff_char (cfg_xoff_char),
        .hi_thresh (cfg_hi_thresh),
        .lo_thresh (cfg_lo_thresh),
        .level     (rx_level),
        .ack       (ins_ack),
        .req       (ins_req),
        .code      (ins_code),
        .rts       (rts),
        .dtr       (dtr)
    );

    fc_tx_gate i_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .inband_en  (cfg_inband_en),
        .rtscts_en  (cfg_rtscts_en),
        .dsrdtr_en  (cfg_dsrdtr_en),
        .xon_char   (cfg_xon_char),
        .xoff_char  (cfg_xoff_char),
        .char_valid (rx_char_valid),
        .char_in    (rx_char),
        .cts        (cts),
        .dsr        (dsr),
        .store      (rx_store),
        .hold       (tx_hold)
    );

    // an inserted control character goes ahead of queued data
    assign tx_allow = !tx_hold && !ins_req;
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
    parameter int LVL_W = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_inband_en,
    input logic       cfg_rtscts_en,
    input logic       cfg_dsrdtr_en,
    input logic [7:0] cfg_xoff_char,
    input logic       rx_char_valid,
    input logic [7:0] rx_char,
    input logic       rx_store,
    input logic       cts,
    input logic       rts,
    input logic       dtr,
    input logic       ins_req,
    input logic       tx_allow
);
    assert_stop_char_pauses_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_inband_en && rx_char_valid && rx_char == cfg_xoff_char) |=> !tx_allow);

    assert_stop_char_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_inband_en && rx_char_valid && rx_char == cfg_xoff_char) |-> !rx_store);

    assert_cts_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rtscts_en && !cts) |=> !tx_allow);

    assert_insert_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ins_req |-> !tx_allow);

    assert_rts_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rtscts_en |=> rts);

    assert_dtr_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dsrdtr_en |=> dtr);
endmodule

bind uart_flow_ctrl fc_checker #(.LVL_W(LVL_W)) i_fc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_inband_en (cfg_inband_en),
    .cfg_rtscts_en (cfg_rtscts_en),
    .cfg_dsrdtr_en (cfg_dsrdtr_en),
    .cfg_xoff_char (cfg_xoff_char),
    .rx_char_valid (rx_char_valid),
    .rx_char       (rx_char),
    .rx_store      (rx_store),
    .cts           (cts),
    .rts           (rts),
    .dtr           (dtr),
    .ins_req       (ins_req),
    .tx_allow      (tx_allow)
);

// File: tb/test_uart_flow_ctrl.sv
module test_uart_flow_ctrl;
    localparam int LW = 8;
    localparam logic [7:0] XON  = 8'h11;
    localparam logic [7:0] XOFF = 8'h13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic inband = 1'b1, rtscts = 1'b1, dsrdtr = 1'b1;
    logic [LW-1:0] level = '0;
    logic rxv = 1'b0;
    logic [7:0] rxc = '0;
    logic cts = 1'b1, dsr = 1'b1, ack = 1'b0;
    logic rx_store, rts, dtr, ins_req, tx_allow;
    logic [7:0] ins_code;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic       rts;
        logic       dtr;
        logic       req;
        logic [7:0] code;
        logic       allow;
        logic       store;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    uart_flow_ctrl #(.LVL_W(LW)) i_uart_flow_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_inband_en(inband), .cfg_rtscts_en(rtscts), .cfg_dsrdtr_en(dsrdtr),
        .cfg_xon_char(XON), .cfg_xoff_char(XOFF),
        .cfg_hi_thresh(8'd12), .cfg_lo_thresh(8'd4),
        .rx_level(level), .rx_char_valid(rxv), .rx_char(rxc), .rx_store(rx_store),
        .cts(cts), .dsr(dsr), .rts(rts), .dtr(dtr),
        .ins_req(ins_req), .ins_code(ins_code), .ins_ack(ack), .tx_allow(tx_allow)
    );

    task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // driver: inputs are already set at a negedge; push what the next edge must give
    task automatic expect_next(input logic e_rts, input logic e_dtr, input logic e_req,
                               input logic [7:0] e_code, input logic e_allow,
                               input logic e_store, input string tag);
        exp_t e;
        e = '{rts: e_rts, dtr: e_dtr, req: e_req, code: e_code,
              allow: e_allow, store: e_store, tag: tag};
        q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: after each edge compare with the oldest expectation
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.tag, "rts", {7'd0, rts}, {7'd0, e.rts});
                cmp(e.tag, "dtr", {7'd0, dtr}, {7'd0, e.dtr});
                cmp(e.tag, "ins_req", {7'd0, ins_req}, {7'd0, e.req});
                if (e.req) cmp(e.tag, "ins_code", ins_code, e.code);
                cmp(e.tag, "tx_allow", {7'd0, tx_allow}, {7'd0, e.allow});
                cmp(e.tag, "rx_store", {7'd0, rx_store}, {7'd0, e.store});
            end
        end
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        expect_next(1, 1, 0, 8'h00, 1, 0, "R1");
        level = 8'd8;  expect_next(1, 1, 0, 8'h00, 1, 0, "R4 below hi");
        level = 8'd12; expect_next(0, 0, 1, XOFF, 0, 0, "R2 R5 throttle");
        expect_next(0, 0, 1, XOFF, 0, 0, "R5 held");
        ack = 1'b1;    expect_next(0, 0, 0, 8'h00, 1, 0, "R5 ack");
        ack = 1'b0; level = 8'd7; expect_next(0, 0, 0, 8'h00, 1, 0, "R4 between");
        level = 8'd4;  expect_next(1, 1, 1, XON, 0, 0, "R3 release");
        ack = 1'b1;    expect_next(1, 1, 0, 8'h00, 1, 0, "R5 ack xon");
        ack = 1'b0; level = 8'd13; expect_next(0, 0, 1, XOFF, 0, 0, "R2 again");
        level = 8'd3;  expect_next(1, 1, 0, 8'h00, 1, 0, "R6 withdraw");
        level = 8'd0;  expect_next(1, 1, 0, 8'h00, 1, 0, "R6 no xon");
        rxv = 1'b1; rxc = XOFF;  expect_next(1, 1, 0, 8'h00, 0, 0, "R7 R8 xoff");
        rxc = 8'h41;             expect_next(1, 1, 0, 8'h00, 0, 1, "R8 data stored");
        rxc = XON;               expect_next(1, 1, 0, 8'h00, 1, 0, "R7 R8 xon");
        rxv = 1'b0; cts = 1'b0;  expect_next(1, 1, 0, 8'h00, 0, 0, "R9 cts");
        cts = 1'b1; dsr = 1'b0;  expect_next(1, 1, 0, 8'h00, 0, 0, "R9 dsr");
        dsr = 1'b1; rtscts = 1'b0; cts = 1'b0; expect_next(1, 1, 0, 8'h00, 1, 0, "R9 cts ignored");
        cts = 1'b1; dsrdtr = 1'b0; dsr = 1'b0; level = 8'd12;
        expect_next(1, 1, 1, XOFF, 0, 0, "R11 lines idle");
        ack = 1'b1;              expect_next(1, 1, 0, 8'h00, 1, 0, "R11 ack");
        ack = 1'b0; dsr = 1'b1; inband = 1'b0; rxv = 1'b1; rxc = XOFF;
        expect_next(1, 1, 0, 8'h00, 1, 1, "R8 inband off");
        inband = 1'b1; rxv = 1'b0; rtscts = 1'b1; dsrdtr = 1'b1;
        expect_next(0, 0, 0, 8'h00, 1, 0, "R2 lines on");
        // same cycle: release and received XOFF
        level = 8'd2; rxv = 1'b1; rxc = XOFF;
        expect_next(1, 1, 1, XON, 0, 0, "R10 R7 same cycle");
        rxv = 1'b0; ack = 1'b1;  expect_next(1, 1, 0, 8'h00, 0, 0, "R7 still paused");
        ack = 1'b0; rxv = 1'b1; rxc = XON; expect_next(1, 1, 0, 8'h00, 1, 0, "R7 resume");
        rxv = 1'b0;
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule